// File: doc/BRIEF.md
# TDM Transmit Slot Mask Engine

This block decides, slot by slot, whether a time-division-multiplexed serial transmitter drives its data pin or leaves it three-stated, and whether the transmit-empty flag may be raised when the word finishes. Software programs a 32-bit mask, one bit per slot with bit N governing slot N. The mask is not used directly. Shortly before each frame ends, the block takes a snapshot of it. At the frame boundary the snapshot is loaded into a hidden shift register. That register moves one place toward bit 0 at the end of every word, so its bit 0 always gates the slot now on the wire.

Software may also post a one-shot skip request. The request three-states the pin for the next slot even when the mask enables that slot. The request does not change the flag qualifier. Timing comes from two strobes: `bit_tick`, which marks each serial bit, and `frame_sync`, which starts the first frame. After that, frames follow back to back for a runtime-chosen number of slots.

A sequencer with four named states drives the block:
- IDLE waits for `frame_sync`.
- RUN covers every slot before the last.
- LAST covers the last slot up to the mask cutoff point.
- LOCK covers the final three bits of the frame, after the snapshot has been taken.

The transitions are:
- IDLE→RUN, or IDLE→LAST for one-slot frames, on `frame_sync`.
- RUN→RUN, or RUN→LAST, on each word end.
- LAST→LOCK on the tick that ends bit WORD_BITS-4 of the last slot.
- LOCK→RUN, or LOCK→LAST for one-slot frames, on the final word end of the frame.

Top module: `tdm_tx_slot_gate`

## Requirements
- R1: After reset, `mask_rd` reads 32'hFFFFFFFF, and `in_frame`, `tx_drive_en` and `tde_set` stay 0 until a `frame_sync` cycle, however many `bit_tick` pulses arrive.
- R2: The clock edge on which `frame_sync` is high in IDLE starts slot 0, bit 0 of the first frame. It loads the gating register from the current mask. During slot k, `tx_drive_en` equals mask bit k (bit 0 is slot 0) when no skip applies.
- R3: `tde_set` is high in the cycle carrying the `bit_tick` of the last bit of a slot whose gating bit is 1. It is never high for a slot whose gating bit is 0.
- R4: A mask write (`wr_en`=1, `wr_sel`=0) shows on `mask_rd` from the next cycle. It leaves the slots of the frame in progress unchanged and takes effect from the next frame.
- R5: The snapshot is taken on the edge that carries the `bit_tick` ending bit WORD_BITS-4 of the last slot. A mask write landing on an earlier edge governs the next frame. A write landing on that edge or later governs only the frame after it.
- R6: A skip write (`wr_en`=1, `wr_sel`=1, data ignored) forces `tx_drive_en` to 0 for the whole of the next slot, including slot 0 of the next frame, even if that slot's mask bit is 1. `tde_set` still follows the mask.
- R7: A skip request is held until the next slot boundary, is consumed there, and affects only one slot. The slot after the skipped one follows the mask again.
- R8: `slots_cfg` sets the number of slots per frame, from 1 to 32. A value of 0 acts as 1, and values above 32 act as 32. After the last slot, the next frame starts at once with slot 0.
- R9: A slot lasts exactly WORD_BITS `bit_tick` pulses, and `tx_drive_en` does not change inside a slot.
- R10: `slot_no` gives the index of the slot in progress, counting from 0 within each frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse that closes the current serial bit |
| frame_sync | input | 1 | Starts the first frame when the block is idle |
| slots_cfg | input | 6 | Slots per frame (clamped to 1..32) |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the mask register, 1 posts a skip request |
| wr_data | input | 32 | Mask value to write |
| mask_rd | output | 32 | Readback of the programmed mask |
| slot_no | output | 5 | Index of the slot in progress |
| in_frame | output | 1 | High while frames are running |
| tx_drive_en | output | 1 | Drive the data pin (0 means three-state) |
| tde_set | output | 1 | Qualifier allowing the transmit-empty flag at the word end |

## Verification
`tx_drive_en` and `slot_no` change on the tick edge that closes a slot's last bit, and they are valid from the next cycle. `tde_set` is combinational in the tick cycle of a slot's last bit. `mask_rd` follows a write one cycle later. A mask write reaches the pin only after the next snapshot and frame load, one or two frames later depending on the cutoff. The bench drives every input just after a rising edge and samples every output at the falling edge. The driver pushes one expected entry per slot into a queue. The monitor counts WORD_BITS ticks to close each slot, then compares the slot index, the drive level (and its stability across the slot) and whether a flag pulse was seen. This makes every comparison land exactly in the cycle the requirement names.

// File: rtl/tsm_pkg.sv
package tsm_pkg;

    // Sequencer states: waiting, ordinary slots, last slot before the
    // cutoff, last bits after the cutoff.
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_LAST = 2'd2,
        SEQ_LOCK = 2'd3
    } seq_state_e;

    // Write-port target select.
    localparam logic SEL_MASK = 1'b0;
    localparam logic SEL_SKIP = 1'b1;

    // Number of closing bit periods of a frame during which mask writes
    // are too late for the next frame.
    localparam int SNAP_LEAD = 3;

endpackage

// File: rtl/tsm_regs.sv
module tsm_regs
    import tsm_pkg::*;
#(
    parameter int MASK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [MASK_W-1:0] wr_data,
    input  logic              slot_bound,
    output logic [MASK_W-1:0] mask_q,
    output logic              skip_pend
);

    logic mask_wr;
    logic skip_wr;

    assign mask_wr = wr_en && (wr_sel == SEL_MASK);
    assign skip_wr = wr_en && (wr_sel == SEL_SKIP);

    // Programmable mask, all slots enabled out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (mask_wr) begin
            mask_q <= wr_data;
        end
    end

    // One-shot skip request: a new write wins over consumption.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            skip_pend <= 1'b0;
        end else if (skip_wr) begin
            skip_pend <= 1'b1;
        end else if (slot_bound) begin
            skip_pend <= 1'b0;
        end
    end

    // R7
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_bound && !skip_wr) |=> !skip_pend);

    // R4
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_wr |=> $stable(mask_q));

endmodule

// File: rtl/tsm_seq.sv
module tsm_seq
    import tsm_pkg::*;
#(
    parameter  int MASK_W    = 32,
    parameter  int WORD_BITS = 8,
    localparam int CNT_W     = $clog2(MASK_W),
    localparam int NUM_W     = $clog2(MASK_W + 1),
    localparam int BIT_W     = $clog2(WORD_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             frame_sync,
    input  logic [NUM_W-1:0] slots_cfg,
    output logic             in_frame,
    output logic [CNT_W-1:0] slot_q,
    output logic             start_now,
    output logic             shift_now,
    output logic             snap_now,
    output logic             load_now,
    output logic             word_end,
    output logic             slot_bound
);

    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_BITS - 1);
    localparam logic [BIT_W-1:0] BIT_SNAP = BIT_W'(WORD_BITS - 1 - SNAP_LEAD);

    seq_state_e       state_q;
    seq_state_e       state_d;
    logic [BIT_W-1:0] bit_q;
    logic [CNT_W-1:0] slot_r;
    logic [NUM_W-1:0] n_eff;
    logic [CNT_W-1:0] last_idx;
    logic             at_bit_last;
    logic             at_bit_snap;
    logic             next_is_last;
    logic             single_slot;

    // Clamp the runtime slot count into 1..MASK_W.
    always_comb begin
        if (slots_cfg == '0) begin
            n_eff = NUM_W'(1);
        end else if (slots_cfg > NUM_W'(MASK_W)) begin
            n_eff = NUM_W'(MASK_W);
        end else begin
            n_eff = slots_cfg;
        end
        last_idx = CNT_W'(n_eff - NUM_W'(1));
    end

    assign at_bit_last  = (bit_q == BIT_LAST);
    assign at_bit_snap  = (bit_q == BIT_SNAP);
    assign single_slot  = (last_idx == '0);
    assign next_is_last = (NUM_W'(slot_r) + NUM_W'(1)) >= NUM_W'(last_idx);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (frame_sync) begin
                    state_d = single_slot ? SEQ_LAST : SEQ_RUN;
                end
            end
            SEQ_RUN: begin
                if (bit_tick && at_bit_last) begin
                    state_d = next_is_last ? SEQ_LAST : SEQ_RUN;
                end
            end
            SEQ_LAST: begin
                if (bit_tick && at_bit_snap) begin
                    state_d = SEQ_LOCK;
                end
            end
            SEQ_LOCK: begin
                if (bit_tick && at_bit_last) begin
                    state_d = single_slot ? SEQ_LAST : SEQ_RUN;
                end
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    // Strobe outputs decoded from the state.
    always_comb begin
        in_frame  = 1'b0;
        start_now = 1'b0;
        shift_now = 1'b0;
        snap_now  = 1'b0;
        load_now  = 1'b0;
        word_end  = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                start_now = frame_sync;
            end
            SEQ_RUN: begin
                in_frame  = 1'b1;
                word_end  = bit_tick && at_bit_last;
                shift_now = bit_tick && at_bit_last;
            end
            SEQ_LAST: begin
                in_frame  = 1'b1;
                word_end  = bit_tick && at_bit_last;
                snap_now  = bit_tick && at_bit_snap;
            end
            SEQ_LOCK: begin
                in_frame  = 1'b1;
                word_end  = bit_tick && at_bit_last;
                load_now  = bit_tick && at_bit_last;
            end
            default: begin
                in_frame = 1'b0;
            end
        endcase
    end

    assign slot_bound = start_now || word_end;

    // Bit and slot counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q  <= '0;
            slot_r <= '0;
        end else if (start_now) begin
            bit_q  <= '0;
            slot_r <= '0;
        end else if (in_frame && bit_tick) begin
            if (at_bit_last) begin
                bit_q  <= '0;
                slot_r <= load_now ? '0 : slot_r + CNT_W'(1);
            end else begin
                bit_q <= bit_q + BIT_W'(1);
            end
        end
    end

    assign slot_q = slot_r;

    // R5
    lock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_LOCK) |-> ($past(state_q) == SEQ_LAST || $past(state_q) == SEQ_LOCK));

    // R8
    run_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_RUN) |-> (slot_r < last_idx));

    // R9
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_frame && !bit_tick) |=> $stable(bit_q) && $stable(slot_r));

endmodule

// File: rtl/tsm_gate.sv
module tsm_gate #(
    parameter int MASK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_now,
    input  logic              load_now,
    input  logic              shift_now,
    input  logic              snap_now,
    input  logic              slot_bound,
    input  logic              word_end,
    input  logic              in_frame,
    input  logic [MASK_W-1:0] mask_q,
    input  logic              skip_pend,
    output logic              tx_drive_en,
    output logic              tde_set
);

    logic [MASK_W-1:0] snap_q;
    logic [MASK_W-1:0] gate_sr;
    logic              skip_act;

    // Cutoff snapshot of the programmed mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '1;
        end else if (snap_now) begin
            snap_q <= mask_q;
        end
    end

    // Hidden gating shift register: bit 0 governs the current slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_sr <= '1;
        end else if (start_now) begin
            gate_sr <= mask_q;
        end else if (load_now) begin
            gate_sr <= snap_q;
        end else if (shift_now) begin
            gate_sr <= {1'b0, gate_sr[MASK_W-1:1]};
        end
    end

    // Skip request applied for exactly one slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            skip_act <= 1'b0;
        end else if (slot_bound) begin
            skip_act <= skip_pend;
        end
    end

    assign tx_drive_en = in_frame && gate_sr[0] && !skip_act;
    assign tde_set     = word_end && gate_sr[0];

    // R2
    shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_now || load_now || shift_now) |=> $stable(gate_sr));

    // R4
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_now |=> $stable(snap_q));

    // R7
    skip_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_bound && skip_act && !skip_pend) |=> !skip_act);

endmodule

// File: rtl/tdm_tx_slot_gate.sv
module tdm_tx_slot_gate #(
    parameter  int MASK_W    = 32,
    parameter  int WORD_BITS = 8,
    localparam int CNT_W     = $clog2(MASK_W),
    localparam int NUM_W     = $clog2(MASK_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              frame_sync,
    input  logic [NUM_W-1:0]  slots_cfg,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [MASK_W-1:0] wr_data,
    output logic [MASK_W-1:0] mask_rd,
    output logic [CNT_W-1:0]  slot_no,
    output logic              in_frame,
    output logic              tx_drive_en,
    output logic              tde_set
);

    logic [MASK_W-1:0] mask_q;
    logic              skip_pend;
    logic              start_now;
    logic              shift_now;
    logic              snap_now;
    logic              load_now;
    logic              word_end;
    logic              slot_bound;

    tsm_regs #(.MASK_W(MASK_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .slot_bound (slot_bound),
        .mask_q     (mask_q),
        .skip_pend  (skip_pend)
    );

    tsm_seq #(.MASK_W(MASK_W), .WORD_BITS(WORD_BITS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .frame_sync (frame_sync),
        .slots_cfg  (slots_cfg),
        .in_frame   (in_frame),
        .slot_q     (slot_no),
        .start_now  (start_now),
        .shift_now  (shift_now),
        .snap_now   (snap_now),
        .load_now   (load_now),
        .word_end   (word_end),
        .slot_bound (slot_bound)
    );

    tsm_gate #(.MASK_W(MASK_W)) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_now   (start_now),
        .load_now    (load_now),
        .shift_now   (shift_now),
        .snap_now    (snap_now),
        .slot_bound  (slot_bound),
        .word_end    (word_end),
        .in_frame    (in_frame),
        .mask_q      (mask_q),
        .skip_pend   (skip_pend),
        .tx_drive_en (tx_drive_en),
        .tde_set     (tde_set)
    );

    assign mask_rd = mask_q;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_frame |-> (!tx_drive_en && !tde_set));

endmodule

// File: tb/tdm_tx_slot_gate_tb_top.sv
module tdm_tx_slot_gate_tb_top;

    localparam int W = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bit_tick;
    logic        frame_sync;
    logic [5:0]  slots_cfg;
    logic        wr_en;
    logic        wr_sel;
    logic [31:0] wr_data;
    logic [31:0] mask_rd;
    logic [4:0]  slot_no;
    logic        in_frame;
    logic        tx_drive_en;
    logic        tde_set;

    always #4 clk = ~clk;   // 125 MHz

    tdm_tx_slot_gate #(.MASK_W(32), .WORD_BITS(W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_tick    (bit_tick),
        .frame_sync  (frame_sync),
        .slots_cfg   (slots_cfg),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .mask_rd     (mask_rd),
        .slot_no     (slot_no),
        .in_frame    (in_frame),
        .tx_drive_en (tx_drive_en),
        .tde_set     (tde_set)
    );

    int checks = 0;
    int fails  = 0;

    logic [6:0] exp_q[$];   // {slot[4:0], drive, flag}
    string      req_q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // One serial bit: a quiet cycle (optional write) then a tick cycle.
    task automatic bit_step(input bit wv, input bit sel, input logic [31:0] d);
        bit_tick = 1'b0;
        wr_en    = wv;
        wr_sel   = sel;
        wr_data  = d;
        @(posedge clk); #1;
        wr_en    = 1'b0;
        bit_tick = 1'b1;
        @(posedge clk); #1;
        bit_tick = 1'b0;
    endtask

    // Driver: push the expected result of every slot, then run the frame.
    task automatic run_frame(input int n, input logic [31:0] m, input logic [31:0] sk,
                             input int n_next, input int wslot, input int wbit,
                             input bit wsel, input logic [31:0] wd, input string req);
        for (int s = 0; s < n; s++) begin
            exp_q.push_back({5'(s), m[s] & ~sk[s], m[s]});
            req_q.push_back(req);
        end
        for (int s = 0; s < n; s++) begin
            for (int b = 0; b < W; b++) begin
                if (s == n - 1 && b == W - 1) slots_cfg = 6'(n_next);
                bit_step(s == wslot && b == wbit, wsel, wd);
            end
        end
    endtask

    // Monitor: close a slot after W ticks and compare with the queue.
    int         mcnt = 0;
    logic       first_drv;
    logic [4:0] first_slot;
    logic       drv_bad;
    logic       flag_seen;

    always @(negedge clk) begin
        if (rst_n && in_frame) begin
            if (mcnt == 0) begin
                first_drv  = tx_drive_en;
                first_slot = slot_no;
                drv_bad    = 1'b0;
                flag_seen  = 1'b0;
            end else if (tx_drive_en != first_drv) begin
                drv_bad = 1'b1;
            end
            if (tde_set) flag_seen = 1'b1;
            if (bit_tick) begin
                mcnt++;
                if (mcnt == W) begin
                    mcnt = 0;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R8", "unexpected slot", 32'(first_slot), 32'hFFFF_FFFF);
                    end else begin
                        logic [6:0] it;
                        string      r;
                        it = exp_q.pop_front();
                        r  = req_q.pop_front();
                        // R10: slot index
                        check(first_slot == it[6:2], "R10", "slot_no", 32'(first_slot), 32'(it[6:2]));
                        check(first_drv == it[1], r, "tx_drive_en", 32'(first_drv), 32'(it[1]));
                        // R9: drive level constant across the slot
                        check(!drv_bad, "R9", "drive stable in slot", 32'(drv_bad), 32'd0);
                        // R3: flag qualifier per slot
                        check(flag_seen == it[0], "R3", "tde_set seen", 32'(flag_seen), 32'(it[0]));
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst_n      = 1'b0;
        bit_tick   = 1'b0;
        frame_sync = 1'b0;
        slots_cfg  = 6'd4;
        wr_en      = 1'b0;
        wr_sel     = 1'b0;
        wr_data    = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        check(mask_rd == 32'hFFFF_FFFF, "R1", "mask_rd after reset", mask_rd, 32'hFFFF_FFFF);
        check(!in_frame && !tx_drive_en && !tde_set, "R1", "idle outputs",
              {29'd0, in_frame, tx_drive_en, tde_set}, 32'd0);
        @(posedge clk); #1;

        // R1: ticks without frame_sync keep the block idle
        for (int i = 0; i < 4; i++) bit_step(1'b0, 1'b0, '0);
        @(negedge clk);
        check(!in_frame && !tx_drive_en, "R1", "idle after ticks",
              {30'd0, in_frame, tx_drive_en}, 32'd0);
        @(posedge clk); #1;

        // R2: start the first frame
        frame_sync = 1'b1;
        @(posedge clk); #1;
        frame_sync = 1'b0;

        // R2: all slots enabled; write mask 5 mid-frame
        run_frame(4, 32'hFFFF_FFFF, 32'h0, 4, 1, 0, 1'b0, 32'h5, "R2");
        @(negedge clk);
        check(mask_rd == 32'h5, "R4", "mask_rd readback", mask_rd, 32'h5);
        @(posedge clk); #1;

        // R4: new mask active now; write just before the cutoff
        run_frame(4, 32'h5, 32'h0, 4, 3, W - 4, 1'b0, 32'hA, "R4");
        // R5: cutoff write took effect; this write lands too late
        run_frame(4, 32'hA, 32'h0, 4, 3, W - 3, 1'b0, 32'h3, "R5");
        // R5: late write still not active; R6: skip slot 1
        run_frame(4, 32'hA, 32'h2, 4, 0, 3, 1'b1, 32'h0, "R6");
        // R7: skip posted in the last slot hits slot 0 of the next frame
        run_frame(4, 32'h3, 32'h0, 1, 3, 2, 1'b1, 32'h0, "R7");
        // R8: one-slot frames
        run_frame(1, 32'h3, 32'h1, 1, -1, 0, 1'b0, 32'h0, "R7");
        run_frame(1, 32'h3, 32'h0, 0, 0, 1, 1'b0, 32'h2, "R8");
        run_frame(1, 32'h2, 32'h0, 40, 0, 1, 1'b0, 32'h8000_0001, "R8");
        // R8: clamped to 32 slots; skip slot 31
        run_frame(32, 32'h8000_0001, 32'h8000_0000, 32, 30, 2, 1'b1, 32'h0, "R8");

        @(negedge clk);
        check(exp_q.size() == 0, "R8", "slots left in queue", 32'(exp_q.size()), 32'd0);
        summary();
        $finish;
    end

endmodule